// File: doc/BRIEF.md
# Asynchronous Serial Port with Flag-Gated Interrupts

This block is a full-duplex asynchronous serial port. A small register port sets up the transmitter and the receiver and moves their data. The transmitter sends frames that begin with a low start bit and end with a high stop bit. Between them it sends either eight or nine data bits, least significant bit first, as the frame-length bit in the control register selects. One transmit word can wait in a holding buffer while another is being shifted out. The receiver looks at its line at sixteen times the bit rate and decides each bit by a two-of-three vote taken at the middle of the bit. It takes a falling edge as a start bit only when the line was high for the three samples before that edge. It also reports when the line has stayed high for a whole frame time after some activity.

Both directions share one sixteen-times tick. The tick comes from a programmable divider of the system clock, or from the rising edges of an external clock pin after those edges are synchronised. Six status flags report the following events: the holding buffer is empty, transmission is complete, receive data is ready, the line is idle, a word was lost to overrun, and a stop bit was bad. Four of these flags each have their own interrupt enable. The flags change in the same way whatever the enables are set to. Software clears a flag in two steps. It first reads the status register while the flag is set. It then accesses the data register with a byte-lane mask that includes the low byte. A read clears the receive-side flags and a write clears the transmit-side flags.

Top module: `sci_uart`

## Requirements
- R1: After reset the status port reads 6'b000011. The bit order is [0] transmit buffer empty, [1] transmit complete, [2] receive full, [3] idle line, [4] overrun, [5] framing error. After reset txd is 1 and irq is 0.
- R2: When the frame-length bit is 0 (control register, address 0, bit 2), a data write sends a 10-bit frame on txd. The frame is a 0 start bit, data bits 0 to 7 with the least significant bit first, and a 1 stop bit. Each bit lasts 16 ticks. With the internal source, one tick is div clocks, where div is the 16-bit baud register at address 1.
- R3: When the frame-length bit is 1, the frame carries 9 data bits and data bit 8 is sent before the stop bit. When the frame-length bit is 0, bit 8 of the written word is ignored and the stop bit follows data bit 7.
- R4: The receiver samples rxd on every tick. It decides each bit by a majority of samples 7, 8 and 9 of that bit. A complete frame sets the receive-full flag and places the data in the data register at address 3 (bit 8 reads 0 in 8-bit mode).
- R5: The transmit buffer empty flag sets when the held word moves into the shifter. The transmit complete flag sets, with txd high, when a stop bit ends and no word is waiting.
- R6: A flag clears only in two steps. First a status read (address 2) while the flag is set. Then a data-register read, which clears the receive-side flags (bits 2 to 5), or a data-register write, which clears the transmit-side flags (bits 0 and 1). A data read with no status read before it leaves receive-full set.
- R7: A data-register access acts (clears flags, or starts a transmission) only when byte-lane enable bit 0 is set. This holds for a byte, half-word or word access. An access with only bit 1 set does nothing.
- R8: The idle flag sets after a whole frame time (160 samples in 8-bit mode, 176 in 9-bit mode) of high samples that follows a received start bit. It does not set before that.
- R9: If the stop bit samples low, the framing-error flag sets. If a frame completes while receive-full is set, the overrun flag sets and the data register keeps the older word.
- R10: The receiver accepts a start bit only on a low sample that follows at least three consecutive high samples.
- R11: irq is the OR of four terms: buffer-empty AND control bit 4, transmit-complete AND bit 5, receive-full AND bit 6, and idle AND bit 7. The flags themselves do not depend on the enables.
- R12: When control bit 3 is 1, each synchronised rising edge of ext_clk is one tick, and the divider is not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 baud divider, 2 status, 3 data |
| bus_be | input | 2 | Byte-lane enables, bit 0 for the low byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data; zero when no read is active |
| rxd | input | 1 | Serial receive line |
| ext_clk | input | 1 | Alternative tick source |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |
| status | output | 6 | Live status flags |

## Verification
A bad transmit bit counter or a bad reload shows on txd within the frame that is being sent. A frame that is too long, too short or shifted is seen at the next mid-bit sample. A bad vote position, start qualification or stop check shows at the stop sample of the frame that follows. It appears as a wrong data word, or as a wrong receive-full, overrun or framing flag. A fault in the arm state of the clearing logic shows only later, at the next data-register access: a flag either stays set or drops without the status read that should come first. A fault in the idle counter shows one frame time after the line goes quiet.

// File: rtl/sci_pkg.sv
package sci_pkg;

    localparam int BUS_W    = 16;
    localparam int WORD_W   = 9;
    localparam int N_FLAGS  = 6;
    localparam int FRAME_W  = 11;

    // status flag positions
    localparam int F_TDRE = 0;
    localparam int F_TC   = 1;
    localparam int F_RDRF = 2;
    localparam int F_IDLE = 3;
    localparam int F_OVR  = 4;
    localparam int F_FE   = 5;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_BAUD = 2'd1,
        REG_STAT = 2'd2,
        REG_DATA = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ilie;
        logic rie;
        logic tcie;
        logic tie;
        logic ext;
        logic nine;
        logic re;
        logic te;
    } ctrl_t;

    // index of the stop bit inside a frame (start bit is index 0)
    function automatic logic [3:0] stop_index(input logic nine);
        return nine ? 4'd10 : 4'd9;
    endfunction

    // number of high samples that make one idle frame
    function automatic logic [7:0] idle_samples(input logic nine);
        return nine ? 8'd176 : 8'd160;
    endfunction

    // serial image, bit 0 leaves first
    function automatic logic [FRAME_W-1:0] build_frame(input logic nine,
                                                       input logic [WORD_W-1:0] d);
        return {1'b1, (nine ? d[8] : 1'b1), d[7:0], 1'b0};
    endfunction

endpackage

// File: rtl/sci_baud.sv
module sci_baud
    import sci_pkg::*;
#(
    parameter int DIV_W   = BUS_W,
    parameter int SYNC_ST = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             use_ext,
    input  logic [DIV_W-1:0] div,
    input  logic             ext_clk,
    output logic             tick16
);

    localparam int SH_W = SYNC_ST + 1;

    logic [DIV_W-1:0] cnt;
    logic [SH_W-1:0]  ext_sh;
    logic             int_tick;
    logic             ext_tick;

    assign int_tick = (div <= DIV_W'(1)) || (cnt >= div - DIV_W'(1));
    assign ext_tick = ext_sh[SH_W-2] & ~ext_sh[SH_W-1];
    assign tick16   = use_ext ? ext_tick : int_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            ext_sh <= '0;
        end else begin
            ext_sh <= {ext_sh[SH_W-2:0], ext_clk};
            if (use_ext || int_tick)
                cnt <= '0;
            else
                cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/sci_tx.sv
module sci_tx
    import sci_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              en,
    input  logic              nine,
    input  logic              pend,
    input  logic [WORD_W-1:0] pend_data,
    output logic              take,
    output logic              done,
    output logic              txd
);

    logic               busy;
    logic [FRAME_W-1:0] sh;
    logic [3:0]         bitn;
    logic [3:0]         phase;
    logic               end_bit;
    logic               can_load;

    always_comb begin
        end_bit  = busy && tick && (phase == 4'd15) && (bitn == stop_index(nine));
        can_load = en && pend && (!busy || end_bit);
        take     = can_load;
        done     = end_bit && !can_load;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            sh    <= '1;
            bitn  <= '0;
            phase <= '0;
        end else if (can_load) begin
            busy  <= 1'b1;
            sh    <= build_frame(nine, pend_data);
            bitn  <= '0;
            phase <= '0;
        end else if (end_bit) begin
            busy  <= 1'b0;
            sh    <= '1;
        end else if (busy && tick) begin
            phase <= phase + 4'd1;
            if (phase == 4'd15) begin
                sh   <= {1'b1, sh[FRAME_W-1:1]};
                bitn <= bitn + 4'd1;
            end
        end
    end

    assign txd = busy ? sh[0] : 1'b1;

endmodule

// File: rtl/sci_rx.sv
module sci_rx
    import sci_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              en,
    input  logic              nine,
    input  logic              rxd,
    output logic              done,
    output logic              stop_ok,
    output logic [WORD_W-1:0] data,
    output logic              idle_hit
);

    logic              busy;
    logic [3:0]        phase;
    logic [3:0]        bitn;
    logic [1:0]        votes;
    logic [WORD_W-1:0] sh;
    logic [1:0]        run;
    logic [7:0]        idle_cnt;
    logic              armed;
    logic [2:0]        tally;
    logic              bit_val;
    logic              decide;
    logic              start_hit;

    always_comb begin
        tally     = {1'b0, votes} + {2'b00, rxd};
        bit_val   = tally >= 3'd2;
        decide    = busy && tick && (phase == 4'd8);
        done      = decide && (bitn == stop_index(nine));
        stop_ok   = bit_val;
        start_hit = en && !busy && tick && !rxd && (run == 2'd3);
        idle_hit  = en && tick && rxd && armed &&
                    (idle_cnt == idle_samples(nine) - 8'd1);
        data      = nine ? sh : {1'b0, sh[WORD_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            busy     <= 1'b0;
            phase    <= '0;
            bitn     <= '0;
            votes    <= '0;
            sh       <= '0;
            run      <= '0;
            idle_cnt <= '0;
            armed    <= 1'b0;
        end else if (tick) begin
            run <= rxd ? ((run == 2'd3) ? run : run + 2'd1) : 2'd0;
            if (!rxd)
                idle_cnt <= '0;
            else if (idle_cnt != idle_samples(nine))
                idle_cnt <= idle_cnt + 8'd1;
            if (idle_hit)
                armed <= 1'b0;

            if (start_hit) begin
                busy  <= 1'b1;
                phase <= 4'd1;
                bitn  <= '0;
                votes <= '0;
                armed <= 1'b1;
            end else if (busy) begin
                phase <= phase + 4'd1;
                if (phase == 4'd15)
                    bitn <= bitn + 4'd1;
                if (phase == 4'd6 || phase == 4'd7)
                    votes <= tally[1:0];
                if (decide) begin
                    votes <= '0;
                    if (bitn == 4'd0) begin
                        if (bit_val)
                            busy <= 1'b0;
                    end else if (done) begin
                        busy <= 1'b0;
                    end else begin
                        sh <= {bit_val, sh[WORD_W-1:1]};
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sci_flag_bank.sv
module sci_flag_bank #(
    parameter int           N       = 6,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] consume,
    input  logic         probe,
    output logic [N-1:0] flag
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic armed;
        always_ff @(posedge clk) begin
            if (rst) begin
                flag[i] <= RST_VAL[i];
                armed   <= 1'b0;
            end else begin
                if (set[i])
                    flag[i] <= 1'b1;
                else if (consume[i] && armed)
                    flag[i] <= 1'b0;
                if (probe)
                    armed <= flag[i];
                else if (consume[i])
                    armed <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sci_uart.sv
module sci_uart
    import sci_pkg::*;
#(
    parameter logic [BUS_W-1:0] RESET_DIV = 16'd4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [1:0]       bus_be,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             rxd,
    input  logic             ext_clk,
    output logic             txd,
    output logic             irq,
    output logic [5:0]       status
);

    localparam logic [N_FLAGS-1:0] FLAG_RST = N_FLAGS'((1 << F_TDRE) | (1 << F_TC));
    localparam logic [N_FLAGS-1:0] TX_GRP   = N_FLAGS'((1 << F_TDRE) | (1 << F_TC));
    localparam logic [N_FLAGS-1:0] RX_GRP   = ~TX_GRP;

    ctrl_t              ctrl;
    logic [BUS_W-1:0]   div_q;
    logic               pend;
    logic [WORD_W-1:0]  tx_buf;
    logic [WORD_W-1:0]  rx_q;
    logic [1:0]         rxd_sync;
    logic [N_FLAGS-1:0] flag_vec;
    logic [N_FLAGS-1:0] flag_set;
    logic [N_FLAGS-1:0] flag_use;
    reg_sel_e           sel;
    logic               rd_stat;
    logic               rd_data_lo;
    logic               wr_data_lo;
    logic               tick16;
    logic               tx_take;
    logic               tx_done;
    logic               rx_done;
    logic               rx_stop_ok;
    logic [WORD_W-1:0]  rx_word;
    logic               rx_idle;

    assign sel        = reg_sel_e'(bus_addr);
    assign rd_stat    = bus_rd && (sel == REG_STAT);
    assign rd_data_lo = bus_rd && (sel == REG_DATA) && bus_be[0];
    assign wr_data_lo = bus_wr && (sel == REG_DATA) && bus_be[0];

    sci_baud #(.DIV_W(BUS_W), .SYNC_ST(2)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .use_ext (ctrl.ext),
        .div     (div_q),
        .ext_clk (ext_clk),
        .tick16  (tick16)
    );

    sci_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick16),
        .en        (ctrl.te),
        .nine      (ctrl.nine),
        .pend      (pend),
        .pend_data (tx_buf),
        .take      (tx_take),
        .done      (tx_done),
        .txd       (txd)
    );

    sci_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick16),
        .en       (ctrl.re),
        .nine     (ctrl.nine),
        .rxd      (rxd_sync[1]),
        .done     (rx_done),
        .stop_ok  (rx_stop_ok),
        .data     (rx_word),
        .idle_hit (rx_idle)
    );

    always_comb begin
        flag_set         = '0;
        flag_set[F_TDRE] = tx_take;
        flag_set[F_TC]   = tx_done;
        flag_set[F_RDRF] = rx_done && !flag_vec[F_RDRF];
        flag_set[F_IDLE] = rx_idle;
        flag_set[F_OVR]  = rx_done && flag_vec[F_RDRF];
        flag_set[F_FE]   = rx_done && !flag_vec[F_RDRF] && !rx_stop_ok;
        flag_use         = (wr_data_lo ? TX_GRP : '0) | (rd_data_lo ? RX_GRP : '0);
    end

    sci_flag_bank #(.N(N_FLAGS), .RST_VAL(FLAG_RST)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set     (flag_set),
        .consume (flag_use),
        .probe   (rd_stat),
        .flag    (flag_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            div_q    <= RESET_DIV;
            pend     <= 1'b0;
            tx_buf   <= '0;
            rx_q     <= '0;
            rxd_sync <= 2'b11;
        end else begin
            rxd_sync <= {rxd_sync[0], rxd};
            if (bus_wr && sel == REG_CTRL && bus_be[0])
                ctrl <= ctrl_t'(bus_wdata[7:0]);
            if (bus_wr && sel == REG_BAUD) begin
                if (bus_be[0]) div_q[7:0]  <= bus_wdata[7:0];
                if (bus_be[1]) div_q[15:8] <= bus_wdata[15:8];
            end
            if (wr_data_lo) begin
                pend   <= 1'b1;
                tx_buf <= bus_wdata[WORD_W-1:0];
            end else if (tx_take) begin
                pend   <= 1'b0;
            end
            if (flag_set[F_RDRF])
                rx_q <= rx_word;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                REG_CTRL: bus_rdata = {8'h00, ctrl};
                REG_BAUD: bus_rdata = div_q;
                REG_STAT: bus_rdata = {{(BUS_W-N_FLAGS){1'b0}}, flag_vec};
                default:  bus_rdata = {{(BUS_W-WORD_W){1'b0}}, rx_q};
            endcase
        end
    end

    assign irq = (ctrl.tie  && flag_vec[F_TDRE]) ||
                 (ctrl.tcie && flag_vec[F_TC])   ||
                 (ctrl.rie  && flag_vec[F_RDRF]) ||
                 (ctrl.ilie && flag_vec[F_IDLE]);

    assign status = flag_vec;

endmodule

// File: rtl/sci_uart_chk.sv
module sci_uart_chk
    import sci_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [1:0]         bus_addr,
    input logic [1:0]         bus_be,
    input logic               txd,
    input logic [N_FLAGS-1:0] flags,
    input logic [WORD_W-1:0]  rx_q
);

    // R1
    flags_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flags[F_TDRE] && flags[F_TC] && !flags[F_RDRF]));

    // R6
    rdrf_clear_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flags[F_RDRF]) |-> $past(bus_rd && bus_addr == 2'd3 && bus_be[0]));

    // R6
    tdre_clear_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flags[F_TDRE]) |-> $past(bus_wr && bus_addr == 2'd3 && bus_be[0]));

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flags[F_RDRF] && $past(flags[F_RDRF])) |-> $stable(rx_q));

    // R5
    tc_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[F_TC]) |-> txd);

endmodule

bind sci_uart sci_uart_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_be   (bus_be),
    .txd      (txd),
    .flags    (flag_vec),
    .rx_q     (rx_q)
);

// File: tb/test_sci_uart.sv
`timescale 1ns/1ps
module test_sci_uart;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [1:0]  bus_be = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        ext_clk = 1'b0;
    logic        txd;
    logic        irq;
    logic [5:0]  status;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    bit  ext_run = 0;
    logic [7:0] ctrl_m = 8'h00;

    always #5 clk = ~clk;

    sci_uart i_sci_uart (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rxd(rxd), .ext_clk(ext_clk),
        .txd(txd), .irq(irq), .status(status)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 2'd0;
        #1;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [1:0] be, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_be = be;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_be = 2'd0;
        #1;
    endtask

    task automatic set_ctrl(input logic [7:0] c);
        bus_write(2'd0, 2'b01, {8'h00, c});
        ctrl_m = c;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // behavioural serial monitor on txd
    task automatic tx_capture(input int nbits, input int bitclk, output int val, output bit framed);
        int to = 0;
        bit st, sp;
        val = 0;
        while (txd !== 1'b0 && to < 5000) begin @(negedge clk); to++; end
        repeat (bitclk / 2) @(negedge clk);
        st = txd;
        for (int i = 0; i < nbits; i++) begin
            repeat (bitclk) @(negedge clk);
            val = val | (int'(txd) << i);
        end
        repeat (bitclk) @(negedge clk);
        sp = txd;
        framed = (st == 1'b0) && (sp == 1'b1);
        #1;
    endtask

    task automatic send_frame(input int val, input int nbits, input bit stopv, input int bitclk);
        @(negedge clk);
        rxd = 1'b0;
        repeat (bitclk) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            rxd = val[i];
            repeat (bitclk) @(negedge clk);
        end
        rxd = stopv;
        repeat (bitclk) @(negedge clk);
        rxd = 1'b1;
        #1;
    endtask

    task automatic clear_all();
        logic [15:0] d;
        bus_read(2'd2, 2'b11, d);
        bus_read(2'd3, 2'b11, d);
    endtask

    // per-clock reference for the interrupt line (R11)
    always @(negedge clk) begin
        #1;
        if (!rst && !finished) begin
            logic exp_irq;
            exp_irq = (ctrl_m[4] & status[0]) | (ctrl_m[5] & status[1]) |
                      (ctrl_m[6] & status[2]) | (ctrl_m[7] & status[3]);
            check(irq === exp_irq, "R11", "irq vs enables", int'(irq), int'(exp_irq));
        end
    end

    // external tick source, rising edge every 16 clocks
    initial begin
        forever begin
            repeat (8) @(negedge clk);
            if (ext_run) ext_clk = ~ext_clk;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int v;
        bit fr;
        bit line_ok;

        wait_clk(4);
        rst = 1'b0;
        wait_clk(1);
        // R1
        check(status == 6'b000011, "R1", "status after reset", status, 6'b000011);
        check(txd === 1'b1, "R1", "txd after reset", txd, 1);
        check(irq === 1'b0, "R1", "irq after reset", irq, 0);

        bus_write(2'd1, 2'b11, 16'd4);
        set_ctrl(8'h03);

        // R2 / R6: clear sequence then 8-bit frame
        bus_read(2'd2, 2'b11, d);
        bus_write(2'd3, 2'b11, 16'h00A5);
        check(status[1:0] == 2'b00, "R6", "tx flags cleared by status read + write", status[1:0], 0);
        tx_capture(8, 64, v, fr);
        check(v == 'hA5, "R2", "8-bit tx data", v, 'hA5);
        check(fr, "R2", "8-bit tx start/stop", fr, 1);
        wait_clk(64);
        // R5
        check(status[1:0] == 2'b11, "R5", "buffer empty and complete after frame", status[1:0], 3);

        // R7: high-lane-only data write does nothing
        bus_read(2'd2, 2'b11, d);
        bus_write(2'd3, 2'b10, 16'h5500);
        check(status[1:0] == 2'b11, "R7", "flags after high-lane write", status[1:0], 3);
        line_ok = 1;
        for (int i = 0; i < 200; i++) begin @(negedge clk); if (txd !== 1'b1) line_ok = 0; end
        check(line_ok, "R7", "txd quiet after high-lane write", line_ok, 1);

        // R3: 9-bit frame
        set_ctrl(8'h07);
        bus_read(2'd2, 2'b11, d);
        bus_write(2'd3, 2'b11, 16'h01A5);
        tx_capture(9, 64, v, fr);
        check(v == 'h1A5, "R3", "9-bit tx data", v, 'h1A5);
        check(fr, "R3", "9-bit tx framing", fr, 1);
        wait_clk(64);

        // R3: bit 8 ignored in 8-bit mode
        set_ctrl(8'h03);
        bus_read(2'd2, 2'b11, d);
        bus_write(2'd3, 2'b11, 16'h01C3);
        tx_capture(8, 64, v, fr);
        check(v == 'hC3, "R3", "8-bit tx ignores bit 8", v, 'hC3);
        check(fr, "R3", "stop follows data bit 7", fr, 1);
        wait_clk(80);

        // R4: receive 8-bit
        send_frame('h3C, 8, 1'b1, 64);
        wait_clk(4);
        check(status[2] == 1'b1, "R4", "receive full set", status[2], 1);
        bus_read(2'd3, 2'b11, d);
        check(d == 16'h003C, "R4", "rx data 8-bit", d, 'h3C);
        // R6: no status read first
        check(status[2] == 1'b1, "R6", "rdrf kept without status read", status[2], 1);
        bus_read(2'd2, 2'b11, d);
        bus_read(2'd3, 2'b10, d);
        check(status[2] == 1'b1, "R7", "rdrf kept after high-lane read", status[2], 1);
        bus_read(2'd3, 2'b01, d);
        check(status[2] == 1'b0, "R6", "rdrf cleared by status read + byte read", status[2], 0);

        // R8: idle after a frame time of ones
        check(status[3] == 1'b0, "R8", "idle not yet", status[3], 0);
        wait_clk(700);
        check(status[3] == 1'b1, "R8", "idle after frame time", status[3], 1);
        set_ctrl(8'h83);
        check(irq === 1'b1, "R11", "irq from idle enable", irq, 1);
        set_ctrl(8'h03);
        check(irq === 1'b0 && status[3] == 1'b1, "R11", "flag kept with enable off", status[3], 1);
        clear_all();
        check(status[3] == 1'b0, "R6", "idle cleared", status[3], 0);

        // R4: receive 9-bit
        set_ctrl(8'h07);
        send_frame('h155, 9, 1'b1, 64);
        wait_clk(4);
        bus_read(2'd3, 2'b11, d);
        check(d == 16'h0155, "R4", "rx data 9-bit", d, 'h155);
        clear_all();

        // R9: framing error, with receive interrupt enabled
        set_ctrl(8'h43);
        send_frame('h81, 8, 1'b0, 64);
        wait_clk(4);
        check(status[5] == 1'b1, "R9", "framing error", status[5], 1);
        check(irq === 1'b1, "R11", "irq from receive enable", irq, 1);
        set_ctrl(8'h03);
        wait_clk(64);
        clear_all();

        // R9: overrun keeps first word
        send_frame('h11, 8, 1'b1, 64);
        wait_clk(128);
        send_frame('h22, 8, 1'b1, 64);
        wait_clk(8);
        check(status[4] == 1'b1, "R9", "overrun", status[4], 1);
        bus_read(2'd3, 2'b11, d);
        check(d == 16'h0011, "R9", "older word kept", d, 'h11);
        clear_all();
        wait_clk(8);

        // R10: start needs three high samples before it
        rxd = 1'b0; wait_clk(768);
        rxd = 1'b1; wait_clk(8);
        rxd = 1'b0; wait_clk(128);
        rxd = 1'b1; wait_clk(800);
        check(status[2] == 1'b1, "R10", "break frame received", status[2], 1);
        check(status[4] == 1'b0, "R10", "short-high start rejected", status[4], 0);
        clear_all();
        send_frame('h5A, 8, 1'b1, 64);
        wait_clk(4);
        bus_read(2'd3, 2'b11, d);
        check(d == 16'h005A, "R10", "qualified start accepted", d, 'h5A);
        clear_all();

        // R12: external tick source
        ext_run = 1;
        set_ctrl(8'h0B);
        wait_clk(40);
        bus_read(2'd2, 2'b11, d);
        bus_write(2'd3, 2'b11, 16'h005A);
        tx_capture(8, 256, v, fr);
        check(v == 'h5A, "R12", "tx data on external ticks", v, 'h5A);
        check(fr, "R12", "framing on external ticks", fr, 1);
        wait_clk(300);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule